// File: doc/BRIEF.md
# Two-stage periodic interrupt timer

This block produces periodic events from two shared 8-bit prescaler counters feeding eight independent 16-bit channel counters. Each prescaler counts down from its own reload value. When it reaches zero it emits a single-cycle tick and reloads itself. Each channel counts down only on ticks from the prescaler it has selected. When a channel is at zero and a selected tick arrives, the channel reloads, raises its timeout flag and, if that channel's interrupt enable is set, drives its interrupt line. A channel loaded with L on a prescaler loaded with M therefore fires once every (L+1)*(M+1) clock cycles.

Software reaches the block over a plain synchronous register interface: one write strobe, one address, write data, and read data that is combinational from the address. A new reload value takes effect only when the counter next passes zero. A force-load control copies a reload value into its counter at once. Flags are cleared by writing ones. A flag-set event beats a clear issued in the same cycle. Disabling the whole block or a single channel wipes the affected flags.

Top module: `ptimer_top`

## Requirements
- R1: After synchronous reset, every readable register, counter and flag reads zero and `irq` is all zero.
- R2: While the block is enabled (address 0x00 bit 0), a prescaler at zero emits a one-cycle tick and reloads from its load register (addresses 0x06, 0x07). Otherwise it decrements by one. While the block is disabled it holds its count.
- R3: An active channel changes its count only on a tick from the prescaler that its select bit names (address 0x02 bit i: 0 means prescaler 0, 1 means prescaler 1).
- R4: An active channel that is at zero when its selected tick arrives reloads from its load register (addresses 0x08+i) and sets flag bit i (address 0x04). The flag period is (L+1)*(M+1) cycles.
- R5: Writing a load register leaves the running count untouched. The new value is used at the next reload.
- R6: Writing one to address 0x05 bit i (channel i) or bit 8+m (prescaler m) copies that load register into its counter at the next edge. A forced channel does not time out in that cycle. Address 0x05 always reads zero.
- R7: Writing one to a flag bit clears it. Writing zero leaves it unchanged.
- R8: If a timeout and a clearing write hit the same flag in the same cycle, the flag ends set.
- R9: All flags read zero while the block is disabled. A channel's flag reads zero while that channel's enable (address 0x01 bit i) is clear. An inactive channel holds its count.
- R10: In the first cycle a channel is active after being inactive, its counter is loaded from its load register.
- R11: `irq[i]` is high exactly when flag i and interrupt enable i (address 0x03 bit i) are both set.
- R12: Channel counts read at 0x10+i and prescaler counts read at 0x18+m. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from `bus_addr` |
| irq | output | 8 | Per-channel interrupt lines |

## Verification
The assertions assume that `bus_wr` is a single-cycle strobe and that `bus_addr` and `bus_wdata` stay steady from one falling clock edge to the next. The stimulus keeps to this by changing inputs only at falling edges.

The set-wins property assumes that a clear can land in exactly the cycle of a timeout. To make that happen, the stimulus predicts the timeout cycle from its own model and aims a clearing write at it. The disable properties assume that enable changes arrive only through register writes. The stimulus toggles the block enable and the channel enables while counters are mid-count, including while flags are pending.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;

    localparam int NCH = 8;
    localparam int NMT = 2;
    localparam int CW  = 16;
    localparam int MW  = 8;
    localparam int AW  = 5;
    localparam int DW  = 16;
    localparam int CIW = $clog2(NCH);
    localparam int MIW = (NMT > 1) ? $clog2(NMT) : 1;

    typedef logic [AW-1:0] addr_t;

    localparam addr_t A_CTRL  = 5'h00;
    localparam addr_t A_CHEN  = 5'h01;
    localparam addr_t A_SEL   = 5'h02;
    localparam addr_t A_IE    = 5'h03;
    localparam addr_t A_FLAG  = 5'h04;
    localparam addr_t A_FORCE = 5'h05;
    localparam addr_t A_MLD   = 5'h06;
    localparam addr_t A_CLD   = 5'h08;
    localparam addr_t A_CCNT  = 5'h10;
    localparam addr_t A_MCNT  = 5'h18;

    typedef struct packed {
        logic          en;
        logic          sel;
        logic          ie;
        logic [CW-1:0] load;
    } chan_cfg_t;

    typedef struct packed {
        logic force_ld;
        logic w1c;
    } chan_cmd_t;

    function automatic logic in_window(addr_t a, addr_t base, int n);
        return (int'(a) >= int'(base)) && (int'(a) < int'(base) + n);
    endfunction

endpackage

// File: rtl/ptimer_micro.sv
module ptimer_micro
    import ptimer_pkg::*;
#(
    parameter int W = MW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         force_ld,
    input  logic [W-1:0] load,
    output logic         tick,
    output logic [W-1:0] cnt
);

    logic at_zero;

    assign at_zero = (cnt == '0);
    assign tick    = run && !force_ld && at_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (force_ld) begin
            cnt <= load;
        end else if (run) begin
            if (at_zero) cnt <= load;
            else         cnt <= cnt - W'(1);
        end
    end

    AST_MT_RELOAD: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cnt == $past(load)));                          // R2
    AST_MT_FORCE: assert property (@(posedge clk) disable iff (rst)
        force_ld |=> (cnt == $past(load)));                      // R6
    AST_MT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!run && !force_ld) |=> $stable(cnt));                   // R2

endmodule

// File: rtl/ptimer_chan.sv
module ptimer_chan
    import ptimer_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           glob_en,
    input  chan_cfg_t      cfg,
    input  chan_cmd_t      cmd,
    input  logic [NMT-1:0] ticks,
    output logic           flag,
    output logic           irq,
    output logic [CW-1:0]  cnt
);

    logic active;
    logic active_q;
    logic tick;
    logic timeout;

    assign active  = glob_en && cfg.en;
    assign tick    = ticks[cfg.sel];
    assign timeout = active && active_q && tick && !cmd.force_ld && (cnt == '0);
    assign irq     = flag && cfg.ie;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            active_q <= 1'b0;
        end else begin
            active_q <= active;
            if (cmd.force_ld) begin
                cnt <= cfg.load;
            end else if (active && !active_q) begin
                cnt <= cfg.load;
            end else if (active && tick) begin
                if (cnt == '0) cnt <= cfg.load;
                else           cnt <= cnt - CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          flag <= 1'b0;
        else if (!active) flag <= 1'b0;
        else if (timeout) flag <= 1'b1;
        else if (cmd.w1c) flag <= 1'b0;
    end

    AST_CH_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        timeout |=> flag);                                        // R8
    AST_CH_W1C: assert property (@(posedge clk) disable iff (rst)
        (active && cmd.w1c && !timeout) |=> !flag);               // R7
    AST_CH_OFF: assert property (@(posedge clk) disable iff (rst)
        !active_q |-> !flag);                                     // R9
    AST_CH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (active && active_q && !tick && !cmd.force_ld) |=> $stable(cnt)); // R3
    AST_CH_START: assert property (@(posedge clk) disable iff (rst)
        (active && !active_q && !cmd.force_ld) |=> (cnt == $past(cfg.load))); // R10

endmodule

// File: rtl/ptimer_regs.sv
module ptimer_regs
    import ptimer_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr,
    input  addr_t                    addr,
    input  logic [DW-1:0]            wdata,
    input  logic [NCH-1:0]           flags,
    input  logic [NCH-1:0][CW-1:0]   ccnt,
    input  logic [NMT-1:0][MW-1:0]   mcnt,
    output logic                     glob_en,
    output chan_cfg_t [NCH-1:0]      cfg,
    output chan_cmd_t [NCH-1:0]      cmd,
    output logic [NMT-1:0][MW-1:0]   mload,
    output logic [NMT-1:0]           force_mt,
    output logic [DW-1:0]            rdata
);

    logic [NCH-1:0]         chen;
    logic [NCH-1:0]         sel;
    logic [NCH-1:0]         ie;
    logic [NCH-1:0][CW-1:0] cload;
    logic [NCH-1:0]         w1c;
    logic [NCH-1:0]         force_ch;
    logic [CIW-1:0]         cidx_ld;
    logic [CIW-1:0]         cidx_cn;
    logic [MIW-1:0]         midx_ld;
    logic [MIW-1:0]         midx_cn;

    assign cidx_ld = CIW'(addr - A_CLD);
    assign cidx_cn = CIW'(addr - A_CCNT);
    assign midx_ld = MIW'(addr - A_MLD);
    assign midx_cn = MIW'(addr - A_MCNT);

    assign w1c      = (wr && addr == A_FLAG)  ? wdata[NCH-1:0]       : '0;
    assign force_ch = (wr && addr == A_FORCE) ? wdata[NCH-1:0]       : '0;
    assign force_mt = (wr && addr == A_FORCE) ? wdata[NCH+NMT-1:NCH] : '0;

    for (genvar i = 0; i < NCH; i++) begin : g_cfg
        assign cfg[i] = '{en: chen[i], sel: sel[i], ie: ie[i], load: cload[i]};
        assign cmd[i] = '{force_ld: force_ch[i], w1c: w1c[i]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            glob_en <= 1'b0;
            chen    <= '0;
            sel     <= '0;
            ie      <= '0;
            cload   <= '0;
            mload   <= '0;
        end else if (wr) begin
            case (addr)
                A_CTRL: glob_en <= wdata[0];
                A_CHEN: chen    <= wdata[NCH-1:0];
                A_SEL:  sel     <= wdata[NCH-1:0];
                A_IE:   ie      <= wdata[NCH-1:0];
                default: ;
            endcase
            if (in_window(addr, A_CLD, NCH)) cload[cidx_ld] <= wdata[CW-1:0];
            if (in_window(addr, A_MLD, NMT)) mload[midx_ld] <= wdata[MW-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL: rdata = DW'(glob_en);
            A_CHEN: rdata = DW'(chen);
            A_SEL:  rdata = DW'(sel);
            A_IE:   rdata = DW'(ie);
            A_FLAG: rdata = DW'(flags);
            default: ;
        endcase
        if (in_window(addr, A_CLD, NCH))  rdata = DW'(cload[cidx_ld]);
        if (in_window(addr, A_CCNT, NCH)) rdata = DW'(ccnt[cidx_cn]);
        if (in_window(addr, A_MLD, NMT))  rdata = DW'(mload[midx_ld]);
        if (in_window(addr, A_MCNT, NMT)) rdata = DW'(mcnt[midx_cn]);
    end

    AST_FORCE_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (addr == A_FORCE) |-> (rdata == '0));                     // R6

endmodule

// File: rtl/ptimer_top.sv
module ptimer_top
    import ptimer_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           bus_wr,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    output logic [NCH-1:0] irq
);

    logic                   glob_en;
    chan_cfg_t [NCH-1:0]    cfg;
    chan_cmd_t [NCH-1:0]    cmd;
    logic [NMT-1:0][MW-1:0] mload;
    logic [NMT-1:0][MW-1:0] mcnt;
    logic [NMT-1:0]         force_mt;
    logic [NMT-1:0]         ticks;
    logic [NCH-1:0]         flags;
    logic [NCH-1:0][CW-1:0] ccnt;

    ptimer_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .flags    (flags),
        .ccnt     (ccnt),
        .mcnt     (mcnt),
        .glob_en  (glob_en),
        .cfg      (cfg),
        .cmd      (cmd),
        .mload    (mload),
        .force_mt (force_mt),
        .rdata    (bus_rdata)
    );

    for (genvar m = 0; m < NMT; m++) begin : g_micro
        ptimer_micro #(.W(MW)) u_micro (
            .clk      (clk),
            .rst      (rst),
            .run      (glob_en),
            .force_ld (force_mt[m]),
            .load     (mload[m]),
            .tick     (ticks[m]),
            .cnt      (mcnt[m])
        );
    end

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        ptimer_chan u_chan (
            .clk     (clk),
            .rst     (rst),
            .glob_en (glob_en),
            .cfg     (cfg[i]),
            .cmd     (cmd[i]),
            .ticks   (ticks),
            .flag    (flags[i]),
            .irq     (irq[i]),
            .cnt     (ccnt[i])
        );
    end

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        !glob_en |=> (irq == '0));                                // R11

endmodule

// File: tb/test_ptimer_top.sv
`timescale 1ns/1ps
module test_ptimer_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr = 1'b0;
    logic [4:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [7:0]  irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ptimer_top i_ptimer_top (
        .clk(clk), .rst(rst), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq)
    );

    // behavioural reference state
    int r_gen, r_chen, r_sel, r_ie, r_flag;
    int r_mload[2], r_mcnt[2], r_cload[8], r_ccnt[8];
    int r_actq[8];

    always @(posedge clk) begin : model
        int tk[2];
        int fw, fc, fm, act, to, nf;
        if (rst) begin
            r_gen = 0; r_chen = 0; r_sel = 0; r_ie = 0; r_flag = 0;
            for (int m = 0; m < 2; m++) begin r_mload[m] = 0; r_mcnt[m] = 0; end
            for (int c = 0; c < 8; c++) begin r_cload[c] = 0; r_ccnt[c] = 0; r_actq[c] = 0; end
        end else begin
            fw = (wr && addr == 5'h04) ? int'(wdata[7:0]) : 0;
            fc = (wr && addr == 5'h05) ? int'(wdata[7:0]) : 0;
            fm = (wr && addr == 5'h05) ? int'(wdata[9:8]) : 0;
            for (int m = 0; m < 2; m++)
                tk[m] = (r_gen != 0 && r_mcnt[m] == 0 && ((fm >> m) & 1) == 0) ? 1 : 0;
            nf = r_flag;
            for (int c = 0; c < 8; c++) begin
                act = (r_gen != 0 && ((r_chen >> c) & 1) != 0) ? 1 : 0;
                to  = (act != 0 && r_actq[c] != 0 && tk[(r_sel >> c) & 1] != 0 &&
                       r_ccnt[c] == 0 && ((fc >> c) & 1) == 0) ? 1 : 0;
                if (((fc >> c) & 1) != 0) r_ccnt[c] = r_cload[c];
                else if (act != 0 && r_actq[c] == 0) r_ccnt[c] = r_cload[c];
                else if (act != 0 && tk[(r_sel >> c) & 1] != 0)
                    r_ccnt[c] = (r_ccnt[c] == 0) ? r_cload[c] : r_ccnt[c] - 1;
                if (act == 0) nf = nf & ~(1 << c);
                else if (to != 0) nf = nf | (1 << c);
                else if (((fw >> c) & 1) != 0) nf = nf & ~(1 << c);
                r_actq[c] = act;
            end
            r_flag = nf;
            for (int m = 0; m < 2; m++) begin
                if (((fm >> m) & 1) != 0) r_mcnt[m] = r_mload[m];
                else if (r_gen != 0) r_mcnt[m] = (r_mcnt[m] == 0) ? r_mload[m] : r_mcnt[m] - 1;
            end
            if (wr) begin
                case (addr)
                    5'h00: r_gen  = int'(wdata[0]);
                    5'h01: r_chen = int'(wdata[7:0]);
                    5'h02: r_sel  = int'(wdata[7:0]);
                    5'h03: r_ie   = int'(wdata[7:0]);
                    5'h06: r_mload[0] = int'(wdata[7:0]);
                    5'h07: r_mload[1] = int'(wdata[7:0]);
                    default: if (addr >= 5'h08 && addr < 5'h10) r_cload[addr - 5'h08] = int'(wdata);
                endcase
            end
        end
    end

    function automatic int mread(int a);
        if (a == 0) return r_gen;
        if (a == 1) return r_chen;
        if (a == 2) return r_sel;
        if (a == 3) return r_ie;
        if (a == 4) return r_flag;
        if (a == 6 || a == 7) return r_mload[a-6];
        if (a >= 8 && a < 16) return r_cload[a-8];
        if (a >= 16 && a < 24) return r_ccnt[a-16];
        if (a == 24 || a == 25) return r_mcnt[a-24];
        return 0;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // R11: interrupt lines against model on every clock
    always @(negedge clk) begin
        if (!rst) check("R11 irq", int'(irq), r_flag & r_ie);
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            errors++;
            $display("FAIL watchdog: actual cycles %0d expected below 50000", cyc);
            finish_run();
        end
    end

    task automatic rd(int a, string tag);
        @(negedge clk);
        addr = 5'(a);
        #1 check(tag, int'(rdata), mread(a));
    endtask

    task automatic idle(int n, string tag);
        for (int k = 0; k < n; k++) rd(k % 26, tag);
    endtask

    task automatic wreg(int a, int d);
        @(negedge clk);
        wr = 1'b1; addr = 5'(a); wdata = 16'(d);
        @(negedge clk);
        wr = 1'b0;
    endtask

    function automatic bit will_fire(int c);
        int s;
        s = (r_sel >> c) & 1;
        return r_gen != 0 && ((r_chen >> c) & 1) != 0 && r_actq[c] != 0 &&
               r_mcnt[s] == 0 && r_ccnt[c] == 0;
    endfunction

    initial begin
        int t1, t2;
        repeat (3) @(negedge clk);
        // R1: reset state read literally
        for (int a = 0; a < 26; a++) begin
            addr = 5'(a);
            #1 check("R1 reset value", int'(rdata), 0);
            @(negedge clk);
        end
        check("R1 irq at reset", int'(irq), 0);
        rst = 1'b0;

        // R12/R2/R4: configure and run
        wreg(6, 2); wreg(7, 0);
        wreg(8, 3); wreg(9, 1); wreg(10, 0);
        wreg(2, 8'h02); wreg(3, 8'hFF); wreg(1, 8'h07);
        wreg(5, 16'h0300);
        rd(24, "R6 micro force-load"); check("R6 micro0 count", int'(rdata), 2);
        wreg(0, 1);
        idle(80, "R2 R4 R12 running");

        // R4: measured period of channel 0 is (3+1)*(2+1)=12
        wreg(4, 8'hFF);
        t1 = 0; t2 = 0;
        for (int k = 0; k < 200 && t1 == 0; k++) begin
            rd(4, "R4 poll"); if (rdata[0]) t1 = cyc;
        end
        wreg(4, 8'h01);
        for (int k = 0; k < 200 && t2 == 0; k++) begin
            rd(4, "R4 poll"); if (rdata[0]) t2 = cyc;
        end
        check("R4 period", t2 - t1, 12);

        // R5: new load does not disturb running count
        wreg(8, 5);
        idle(90, "R5 deferred reload");

        // R6: channel force-load and force reads zero
        wreg(5, 16'h0001);
        rd(16, "R6 channel force"); check("R6 channel0 count", int'(rdata), 5);
        rd(5, "R6 force reads zero"); check("R6 force literal", int'(rdata), 0);
        idle(30, "R6 after force");

        // R7: zero write no effect, one clears
        wreg(4, 0); idle(6, "R7 zero write");
        wreg(4, 8'hFF); idle(30, "R7 clear");

        // R8: clear aimed at the timeout cycle
        wreg(4, 8'hFF);
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (will_fire(0)) begin
                wr = 1'b1; addr = 5'h04; wdata = 16'h0001;
                break;
            end
        end
        @(negedge clk); wr = 1'b0;
        rd(4, "R8 set wins"); check("R8 flag0 literal", int'(rdata[0]), 1);

        // R9: channel disable then module disable
        wreg(1, 8'h05);
        rd(4, "R9 channel off"); check("R9 flag1 literal", int'(rdata[1]), 0);
        idle(30, "R9 channel off");
        wreg(0, 0);
        rd(4, "R9 module off"); check("R9 flags literal", int'(rdata), 0);
        idle(40, "R9 hold");

        // R10: restart from load
        wreg(1, 8'h07);
        wreg(0, 1);
        idle(60, "R10 restart");

        // R3: selection swap, R11: partial interrupt enable
        wreg(2, 8'h01); wreg(3, 8'h01);
        idle(80, "R3 R11 select");
        wreg(6, 0); wreg(5, 16'h0100);
        idle(40, "R3 fast prescaler");

        finish_run();
    end

endmodule